// File: doc/BRIEF.md
# Banked Host Register Port with Stereo Mixer

This block sits between a host processor and the synthesis core of a six-channel FM sound unit. The host uses an 8-bit data bus and a 2-bit port select. Two of the four port codes load a register address, and each of them also records which of two register banks the next data write is aimed at. The other two codes are data ports, one per bank. Data that reaches the register file is stored at a 9-bit location whose top bit is the bank. The synthesis core reads the register file through a separate combinational read port.

The block also produces the final stereo output. Each channel output comes in as a signed word. Two bits of a per-channel panning register gate the channel into the left sum, the right sum or both. The two sums are shifted right arithmetically and saturated to a signed 16-bit range. A control bit in bank 0 replaces the sixth channel with an 8-bit offset-binary sample written by the host. A read at any port code returns a status byte built from the busy and timer-overflow inputs.

Top module: `fm_host_port`

## Requirements
- R1: A write with port code 0 loads the register address from the data bus and selects bank 0. Port code 2 does the same and selects bank 1.
- R2: A write with port code 1 while bank 0 is selected stores the data byte at location {0, address}. The stored byte is visible on the register read port after the next clock edge.
- R3: A data write whose bank (code 1 means bank 0, code 3 means bank 1) differs from the selected bank changes no register location.
- R4: A write with port code 3 while bank 1 is selected stores the data byte at location 0x100 | address.
- R5: Location 0x02A holds the direct sample. Bit 7 of location 0x02B enables sample mode. In sample mode, channel six contributes (sample − 0x80)·64 instead of its input, still under its own pan bits. Writes to 0x12A and 0x12B have no effect on the sample path.
- R6: A read (rd_en high) at any port code loads rdata on the next edge with {busy, 5'b0, timer_b_flag, timer_a_flag}.
- R7: After reset, locations 0x0B4–0x0B6 and 0x1B4–0x1B6 hold 0xC0 and every other location holds 0, so sample mode is off. The address and bank latches reset to 0.
- R8: Channel k (k = 0..2) uses pan location 0x0B4+k and channel k+3 uses 0x1B4+k. Bit 7 enables the left sum and bit 6 enables the right sum.
- R9: Each side's sum is shifted right arithmetically by MIX_SHIFT (default 0) and clipped to the range +32767 to −32768.
- R10: mix_left and mix_right are registered. They reflect the channel inputs and register contents present before the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_sel | input | 2 | Port code: 0/2 address for bank 0/1, 1/3 data for bank 0/1 |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered status byte |
| busy | input | 1 | Busy flag from the core |
| timer_a_flag | input | 1 | Timer A overflow flag |
| timer_b_flag | input | 1 | Timer B overflow flag |
| reg_raddr | input | 9 | Register read address from the core |
| reg_rdata | output | 8 | Register read data |
| ch_out | input | NUM_CH*CH_W | Packed signed channel outputs, channel 0 in the low bits |
| mix_left | output | OUT_W | Saturated left output |
| mix_right | output | OUT_W | Saturated right output |

## Verification
The mixer is tested with several input patterns. Uniform small values on all channels with every pan bit set check plain summation. Equal large positive or negative values on every channel drive both saturation limits, and a large sum that stays below the limit shows that clipping does not start early. A single non-zero channel with a one-sided pan separates the left gate from the right gate, and a second channel in bank 1 shows that bank 1 pan locations are decoded. In sample mode, the two extreme sample codes show the sign of the offset conversion. A fixed FM value on channel six, compared across sample mode on and off, shows that the sample replaces the input rather than adding to it.

// File: rtl/fm_port_pkg.sv
package fm_port_pkg;
   localparam int unsigned REG_AW = 8;
   localparam logic [7:0] REG_DAC_SAMPLE = 8'h2A;
   localparam logic [7:0] REG_DAC_CTRL   = 8'h2B;
   localparam logic [7:0] REG_PAN_BASE   = 8'hB4;
   localparam logic [7:0] PAN_RESET      = 8'hC0;
   localparam int unsigned PAN_L_BIT     = 7;
   localparam int unsigned PAN_R_BIT     = 6;
   localparam int unsigned DAC_EN_BIT    = 7;

   typedef enum logic [1:0] {
      PORT_ADDR_B0 = 2'd0,
      PORT_DATA_B0 = 2'd1,
      PORT_ADDR_B1 = 2'd2,
      PORT_DATA_B1 = 2'd3
   } port_code_e;
endpackage

// File: rtl/fm_port_decode.sv
module fm_port_decode
   import fm_port_pkg::*;
#(
   parameter int unsigned AW = REG_AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    port_sel,
   input  logic [7:0]    wdata,
   output logic          we,
   output logic [AW:0]   waddr,
   output logic [7:0]    wdat,
   output logic [AW-1:0] addr_q,
   output logic          bank_q
);
   if (AW != 8) begin : g_bad_aw
      $error("fm_port_decode: address width must match the 8-bit bus");
   end

   logic is_addr_port;
   assign is_addr_port = ~port_sel[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         bank_q <= 1'b0;
      end else if (wr_en && is_addr_port) begin
         addr_q <= wdata;
         bank_q <= port_sel[1];
      end
   end

   assign we    = wr_en && port_sel[0] && (port_sel[1] == bank_q);
   assign waddr = {bank_q, addr_q};
   assign wdat  = wdata;
endmodule

// File: rtl/fm_port_regfile.sv
module fm_port_regfile
   import fm_port_pkg::*;
#(
   parameter int unsigned AW     = REG_AW,
   parameter int unsigned NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW:0]       waddr,
   input  logic [7:0]        wdat,
   input  logic [AW:0]       raddr,
   output logic [7:0]        rdat,
   output logic [NUM_CH-1:0] pan_l,
   output logic [NUM_CH-1:0] pan_r,
   output logic [7:0]        dac_sample,
   output logic              dac_on
);
   localparam int unsigned DEPTH = 2 << AW;
   localparam int unsigned HALF  = NUM_CH / 2;

   logic [7:0] mem [DEPTH];

   function automatic logic [7:0] init_val(input logic [AW:0] a);
      logic [AW-1:0] lo;
      lo = a[AW-1:0];
      if (lo >= REG_PAN_BASE && lo < REG_PAN_BASE + 8'(HALF)) return PAN_RESET;
      return 8'h00;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_val((AW+1)'(i));
      end else if (we) begin
         mem[waddr] <= wdat;
      end
   end

   assign rdat = mem[raddr];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_pan_tap
      localparam logic [AW:0] LOC = {1'(g / HALF), REG_PAN_BASE + 8'(g % HALF)};
      assign pan_l[g] = mem[LOC][PAN_L_BIT];
      assign pan_r[g] = mem[LOC][PAN_R_BIT];
   end

   assign dac_sample = mem[{1'b0, REG_DAC_SAMPLE}];
   assign dac_on     = mem[{1'b0, REG_DAC_CTRL}][DAC_EN_BIT];
endmodule

// File: rtl/fm_port_mix.sv
module fm_port_mix #(
   parameter int unsigned NUM_CH    = 6,
   parameter int unsigned CH_W      = 16,
   parameter int unsigned OUT_W     = 16,
   parameter int unsigned MIX_SHIFT = 0,
   parameter int unsigned DAC_W     = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*CH_W-1:0]   ch_out,
   input  logic [NUM_CH-1:0]        pan_l,
   input  logic [NUM_CH-1:0]        pan_r,
   input  logic                     dac_on,
   input  logic signed [DAC_W-1:0]  dac_val,
   output logic signed [OUT_W-1:0]  mix_l,
   output logic signed [OUT_W-1:0]  mix_r
);
   localparam int unsigned SUM_W = CH_W + $clog2(NUM_CH) + 1;
   localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

   if (CH_W <= DAC_W) begin : g_bad_dac
      $error("fm_port_mix: channel width must exceed sample width");
   end
   if (SUM_W <= OUT_W) begin : g_bad_out
      $error("fm_port_mix: output width must be below the sum width");
   end

   logic signed [SUM_W-1:0] term_l [NUM_CH];
   logic signed [SUM_W-1:0] term_r [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic [CH_W-1:0] src;
      if (g == NUM_CH - 1) begin : g_dac_sel
         assign src = dac_on ? {{(CH_W-DAC_W){dac_val[DAC_W-1]}}, dac_val}
                             : ch_out[g*CH_W +: CH_W];
      end else begin : g_fm_only
         assign src = ch_out[g*CH_W +: CH_W];
      end
      assign term_l[g] = pan_l[g] ? {{(SUM_W-CH_W){src[CH_W-1]}}, src} : '0;
      assign term_r[g] = pan_r[g] ? {{(SUM_W-CH_W){src[CH_W-1]}}, src} : '0;
   end

   logic signed [SUM_W-1:0] sum_l, sum_r, sh_l, sh_r;
   always_comb begin
      sum_l = '0;
      sum_r = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         sum_l = sum_l + term_l[i];
         sum_r = sum_r + term_r[i];
      end
      sh_l = sum_l >>> MIX_SHIFT;
      sh_r = sum_r >>> MIX_SHIFT;
   end

   function automatic logic signed [OUT_W-1:0] clip(input logic signed [SUM_W-1:0] v);
      if (v > MAXV) return MAXV[OUT_W-1:0];
      if (v < MINV) return MINV[OUT_W-1:0];
      return v[OUT_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mix_l <= '0;
         mix_r <= '0;
      end else begin
         mix_l <= clip(sh_l);
         mix_r <= clip(sh_r);
      end
   end
endmodule

// File: rtl/fm_host_port.sv
module fm_host_port
   import fm_port_pkg::*;
#(
   parameter int unsigned NUM_CH    = 6,
   parameter int unsigned CH_W      = 16,
   parameter int unsigned OUT_W     = 16,
   parameter int unsigned MIX_SHIFT = 0,
   parameter int unsigned DAC_SHIFT = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [1:0]              port_sel,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   input  logic                    busy,
   input  logic                    timer_a_flag,
   input  logic                    timer_b_flag,
   input  logic [REG_AW:0]         reg_raddr,
   output logic [7:0]              reg_rdata,
   input  logic [NUM_CH*CH_W-1:0]  ch_out,
   output logic [OUT_W-1:0]        mix_left,
   output logic [OUT_W-1:0]        mix_right
);
   localparam int unsigned DAC_W = 8 + DAC_SHIFT;

   if (NUM_CH % 2 != 0 || NUM_CH > 8 || NUM_CH < 2) begin : g_bad_ch
      $error("fm_host_port: channel count must be even, 2 to 8");
   end

   logic              rf_we;
   logic [REG_AW:0]   rf_waddr;
   logic [7:0]        rf_wdat;
   logic [REG_AW-1:0] addr_q;
   logic              bank_q;
   logic [NUM_CH-1:0] pan_l_bits, pan_r_bits;
   logic [7:0]        dac_sample;
   logic              dac_on;
   logic signed [DAC_W-1:0] dac_val;
   logic signed [OUT_W-1:0] mix_l_s, mix_r_s;

   fm_port_decode #(.AW(REG_AW)) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
      .we(rf_we), .waddr(rf_waddr), .wdat(rf_wdat), .addr_q(addr_q), .bank_q(bank_q)
   );

   fm_port_regfile #(.AW(REG_AW), .NUM_CH(NUM_CH)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdat(rf_wdat),
      .raddr(reg_raddr), .rdat(reg_rdata), .pan_l(pan_l_bits), .pan_r(pan_r_bits),
      .dac_sample(dac_sample), .dac_on(dac_on)
   );

   // offset binary to two's complement is a flip of the top bit
   assign dac_val = {~dac_sample[7], dac_sample[6:0], {DAC_SHIFT{1'b0}}};

   fm_port_mix #(.NUM_CH(NUM_CH), .CH_W(CH_W), .OUT_W(OUT_W),
                 .MIX_SHIFT(MIX_SHIFT), .DAC_W(DAC_W)) u_mix (
      .clk(clk), .rst_n(rst_n), .ch_out(ch_out), .pan_l(pan_l_bits), .pan_r(pan_r_bits),
      .dac_on(dac_on), .dac_val(dac_val), .mix_l(mix_l_s), .mix_r(mix_r_s)
   );

   assign mix_left  = mix_l_s;
   assign mix_right = mix_r_s;

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= 8'h00;
      else if (rd_en) rdata <= {busy, 5'b00000, timer_b_flag, timer_a_flag};
   end
endmodule

// File: rtl/fm_host_port_chk.sv
module fm_host_port_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned OUT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [1:0]        port_sel,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              busy,
   input logic              timer_a_flag,
   input logic              timer_b_flag,
   input logic              rf_we,
   input logic [8:0]        rf_waddr,
   input logic [7:0]        addr_q,
   input logic [NUM_CH-1:0] pan_l_bits,
   input logic [OUT_W-1:0]  mix_left
);
   logic seen_bank;
   always_ff @(posedge clk) begin
      if (!rst_n)                    seen_bank <= 1'b0;
      else if (wr_en && !port_sel[0]) seen_bank <= port_sel[1];
   end

   p_addr_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_sel[0]) |=> (addr_q == $past(wdata)));

   p_drop_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel[0] && (port_sel[1] != seen_bank)) |-> !rf_we);

   p_bank1_loc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && port_sel == 2'd3) |-> rf_waddr[8]);

   p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rdata == {$past(busy), 5'b00000, $past(timer_b_flag), $past(timer_a_flag)}));

   p_left_muted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pan_l_bits == '0) |=> (mix_left == '0));
endmodule

bind fm_host_port fm_host_port_chk #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
   .wdata(wdata), .rdata(rdata), .busy(busy), .timer_a_flag(timer_a_flag),
   .timer_b_flag(timer_b_flag), .rf_we(rf_we), .rf_waddr(rf_waddr), .addr_q(addr_q),
   .pan_l_bits(pan_l_bits), .mix_left(mix_left)
);

// File: tb/fm_host_port_tb.sv
module fm_host_port_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] port_sel = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic busy = 1'b0, ta = 1'b0, tb = 1'b0;
   logic [8:0] reg_raddr = 9'h000;
   logic [7:0] reg_rdata;
   logic [95:0] ch_out;
   logic [15:0] mix_left, mix_right;
   logic signed [15:0] chv [6];
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   always_comb for (int i = 0; i < 6; i++) ch_out[i*16 +: 16] = chv[i];

   fm_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
      .wdata(wdata), .rdata(rdata), .busy(busy), .timer_a_flag(ta), .timer_b_flag(tb),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .ch_out(ch_out),
      .mix_left(mix_left), .mix_right(mix_right)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] p, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; port_sel = p; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input string req, input logic [8:0] a, input int exp);
      reg_raddr = a;
      #1;
      chk(req, int'(reg_rdata), exp);
   endtask

   task automatic set_all(input int v);
      for (int i = 0; i < 6; i++) chv[i] = 16'(v);
   endtask

   task automatic mix_is(input string req, input int l, input int r);
      @(negedge clk);
      chk({req, " left"}, int'($signed(mix_left)), l);
      chk({req, " right"}, int'($signed(mix_right)), r);
   endtask

   task automatic t_reset;
      peek("R7 pan 0x0B4", 9'h0B4, 8'hC0);
      peek("R7 pan 0x1B6", 9'h1B6, 8'hC0);
      peek("R7 reg 0x030", 9'h030, 0);
      peek("R7 dac ctrl", 9'h02B, 0);
      chk("R7 rdata", int'(rdata), 0);
      set_all(100);
      mix_is("R7 all pans on, sample mode off", 600, 600);
   endtask

   task automatic t_register_timing;
      @(negedge clk);
      set_all(-7);
      #1;
      chk("R10 before edge", int'($signed(mix_left)), 600);
      mix_is("R10 after edge", -42, -42);
   endtask

   task automatic t_banks;
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h7F);
      peek("R2 bank0 store", 9'h040, 8'h7F);
      wr(2'd2, 8'h40);
      wr(2'd3, 8'h11);
      peek("R4 bank1 store", 9'h140, 8'h11);
      peek("R1 bank0 intact", 9'h040, 8'h7F);
      wr(2'd1, 8'h55);
      peek("R3 bank0 port dropped", 9'h040, 8'h7F);
      peek("R3 bank1 unchanged", 9'h140, 8'h11);
      wr(2'd0, 8'h41);
      wr(2'd3, 8'h66);
      peek("R3 bank1 port dropped", 9'h141, 0);
      peek("R1 new address unused", 9'h041, 0);
      wr(2'd1, 8'h22);
      peek("R1 readdressed store", 9'h041, 8'h22);
   endtask

   task automatic t_status;
      @(negedge clk);
      busy = 1'b1; tb = 1'b0; ta = 1'b1; rd_en = 1'b1; port_sel = 2'd2;
      @(negedge clk);
      chk("R6 busy+A code2", int'(rdata), 8'h81);
      busy = 1'b0; tb = 1'b1; ta = 1'b0; port_sel = 2'd1;
      @(negedge clk);
      chk("R6 B code1", int'(rdata), 8'h02);
      tb = 1'b0; port_sel = 2'd3;
      @(negedge clk);
      chk("R6 clear code3", int'(rdata), 0);
      rd_en = 1'b0;
   endtask

   task automatic t_dac;
      set_all(0);
      chv[5] = 16'sd3000;
      wr(2'd0, 8'h2A); wr(2'd1, 8'hFF);
      wr(2'd0, 8'h2B); wr(2'd1, 8'h80);
      mix_is("R5 sample 0xFF", 8128, 8128);
      wr(2'd0, 8'h2A); wr(2'd1, 8'h00);
      mix_is("R5 sample 0x00", -8192, -8192);
      wr(2'd2, 8'h2A); wr(2'd3, 8'h40);
      mix_is("R5 bank1 sample ignored", -8192, -8192);
      wr(2'd2, 8'h2B); wr(2'd3, 8'h00);
      mix_is("R5 bank1 ctrl ignored", -8192, -8192);
      wr(2'd0, 8'h2B); wr(2'd1, 8'h00);
      mix_is("R5 sample mode off", 3000, 3000);
   endtask

   task automatic t_saturate;
      @(negedge clk);
      set_all(32767);
      mix_is("R9 positive clip", 32767, 32767);
      set_all(-32768);
      mix_is("R9 negative clip", -32768, -32768);
      set_all(0);
      chv[0] = 16'sd10000; chv[1] = 16'sd10000; chv[2] = 16'sd10000;
      mix_is("R9 below limit", 30000, 30000);
   endtask

   task automatic t_pan;
      set_all(0);
      chv[0] = 16'sd1000;
      wr(2'd0, 8'hB4); wr(2'd1, 8'h80);
      mix_is("R8 ch1 left only", 1000, 0);
      chv[3] = -16'sd500;
      wr(2'd2, 8'hB4); wr(2'd3, 8'h40);
      mix_is("R8 ch4 right only", 1000, -500);
      wr(2'd0, 8'hB4); wr(2'd1, 8'h00);
      mix_is("R8 ch1 muted", 0, -500);
   endtask

   initial begin
      set_all(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_register_timing();
      t_banks();
      t_status();
      t_dac();
      t_saturate();
      t_pan();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule